// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block sits next to a processor core's fetch logic. Each cycle it looks at the pending interrupt requests from 18 peripheral sources and at a reset event. It then works out the program-memory word address the core must branch to. Two separate controls decide where the target lies. A boot-reset configuration bit moves the reset target, and a vector-select bit moves the interrupt table. Both can move their target from the bottom of program memory to the start of the boot section. The boot section start comes from a 2-bit boot-size setting.

Interrupts can be held back in two ways. One is the global enable or an external change-window hold. The other is lock masking, which depends on the flash section the program counter is executing from and on which section holds the table. When a vector is issued, the block raises a strobe, drives the address, and sends a one-hot acknowledge to the winning source. All outputs are registered, so they show the decision for the inputs seen one clock earlier.

Top module: `irq_vector_gen`

## Requirements
- R1: While `rst_n` is low, and until the first vector after it rises, `vec_valid` is 0, `vec_ack` is all zeros and `vec_addr` is 0x000.
- R2: `reset_evt` high in a cycle gives, one cycle later, `vec_valid`=1 with `vec_ack`=0. The address is 0x000 when `boot_rst_n`=1 (unprogrammed). This holds whatever the values of `gie`, the locks, `chg_hold` and `irq_req`.
- R3: With `boot_rst_n`=0 (programmed), a reset event gives the boot section start as the address.
- R4: The boot section start is set by `boot_size`: 2'b00 gives 0x800, 2'b01 gives 0xC00, 2'b10 gives 0xE00 and 2'b11 gives 0xF00.
- R5: With `vec_sel`=0, an accepted request on `irq_req` bit i (0 to 17) gives address i+1 (0x001 to 0x012). Bit 0 is external request 0 and bit 17 is store-program-memory ready. The sources follow the fixed slot order: ext0, ext1, timer2 compare, timer2 overflow, timer1 capture, timer1 compare A, timer1 compare B, timer1 overflow, timer0 overflow, SPI done, USART receive done, USART data empty, USART transmit done, ADC done, EEPROM ready, analog comparator, two-wire, store-program-memory ready.
- R6: With `vec_sel`=1, the address is the boot section start + i + 1. For example, it runs from 0xC01 to 0xC12 when `boot_size`=2'b01.
- R7: When several requests are pending, the lowest bit index wins. A reset event overrides every request and acknowledges none.
- R8: With `gie`=0, no interrupt vector or acknowledge is issued.
- R9: With `vec_sel`=1, `lock_app_exec`=1 and `pc_in_boot`=0, interrupts are blocked. With `pc_in_boot`=1 in the same setting, they are accepted.
- R10: With `vec_sel`=0, `lock_boot_exec`=1 and `pc_in_boot`=1, interrupts are blocked. With `pc_in_boot`=0 in the same setting, they are accepted.
- R11: With `chg_hold`=1, no interrupt vector is issued.
- R12: An accepted interrupt raises exactly one `vec_ack` bit, the winner's, in the same cycle as `vec_valid`. In cycles without a vector, `vec_valid` is 0, `vec_ack` is 0 and `vec_addr` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_evt | input | 1 | Reset event requesting the reset vector |
| irq_req | input | 18 | Pending requests, bit 0 is the highest priority |
| gie | input | 1 | Global interrupt enable |
| boot_rst_n | input | 1 | Boot-reset config, 0 = programmed (reset to boot start) |
| vec_sel | input | 1 | 1 = interrupt table at the boot section start |
| boot_size | input | 2 | Boot section size select |
| lock_app_exec | input | 1 | Lock: block interrupts from application code when the table is in boot |
| lock_boot_exec | input | 1 | Lock: block interrupts from boot code when the table is in application |
| pc_in_boot | input | 1 | Core is currently executing from the boot section |
| chg_hold | input | 1 | Table-change window in progress, blocks interrupts |
| vec_valid | output | 1 | Vector issued this cycle |
| vec_addr | output | 12 | Target word address |
| vec_ack | output | 18 | One-hot acknowledge to the winning source |

## Verification
The properties assume that `reset_evt` stays low while `rst_n` is low. They also assume that every input is stable around the sampling edge, so that each registered output can be related to the inputs one cycle earlier. The bench drives all inputs on the falling clock edge and keeps `reset_evt` at 0 throughout reset. It returns every control to an idle setting between scenarios, so that no request left over from one scenario is counted as an acknowledge in the next.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
    localparam int unsigned IVG_SRC_N  = 18;
    localparam int unsigned IVG_ADDR_W = 12;
    localparam int unsigned IVG_IDX_W  = $clog2(IVG_SRC_N);

    // Boot section start in words, per size select
    function automatic logic [IVG_ADDR_W-1:0] boot_start(input logic [1:0] sz);
        logic [IVG_ADDR_W-1:0] s;
        case (sz)
            2'b00:   s = 12'h800;
            2'b01:   s = 12'hC00;
            2'b10:   s = 12'hE00;
            default: s = 12'hF00;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/ivg_prio_enc.sv
module ivg_prio_enc #(
    parameter int unsigned N     = 18,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        // scan downward so the lowest set bit is the last assignment
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ivg_base_sel.sv
module ivg_base_sel
    import ivg_pkg::*;
(
    input  logic                  boot_rst_n,
    input  logic                  vec_sel,
    input  logic [1:0]            boot_size,
    output logic [IVG_ADDR_W-1:0] reset_addr,
    output logic [IVG_ADDR_W-1:0] irq_base
);
    logic [IVG_ADDR_W-1:0] bstart;

    always_comb begin
        bstart     = boot_start(boot_size);
        reset_addr = boot_rst_n ? '0 : bstart;
        irq_base   = vec_sel ? bstart : '0;
    end
endmodule

// File: rtl/ivg_lock_gate.sv
module ivg_lock_gate (
    input  logic gie,
    input  logic chg_hold,
    input  logic vec_sel,
    input  logic lock_app_exec,
    input  logic lock_boot_exec,
    input  logic pc_in_boot,
    output logic allow
);
    logic lock_blk;

    always_comb begin
        lock_blk = (vec_sel  && lock_app_exec  && !pc_in_boot) ||
                   (!vec_sel && lock_boot_exec &&  pc_in_boot);
        allow    = gie && !chg_hold && !lock_blk;
    end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import ivg_pkg::*;
#(
    parameter int unsigned SRC_N  = IVG_SRC_N,
    parameter int unsigned ADDR_W = IVG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_evt,
    input  logic [SRC_N-1:0]  irq_req,
    input  logic              gie,
    input  logic              boot_rst_n,
    input  logic              vec_sel,
    input  logic [1:0]        boot_size,
    input  logic              lock_app_exec,
    input  logic              lock_boot_exec,
    input  logic              pc_in_boot,
    input  logic              chg_hold,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [SRC_N-1:0]  vec_ack
);
    localparam int unsigned IDX_W = $clog2(SRC_N);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [SRC_N-1:0]  ack;
    } vec_state_t;

    vec_state_t st_d, st_q;

    logic                  hit;
    logic [IDX_W-1:0]      win_idx;
    logic                  allow;
    logic [IVG_ADDR_W-1:0] reset_addr, irq_base;

    ivg_prio_enc #(.N(SRC_N), .IDX_W(IDX_W)) u_prio (
        .req (irq_req),
        .hit (hit),
        .idx (win_idx)
    );

    ivg_base_sel u_base (
        .boot_rst_n (boot_rst_n),
        .vec_sel    (vec_sel),
        .boot_size  (boot_size),
        .reset_addr (reset_addr),
        .irq_base   (irq_base)
    );

    ivg_lock_gate u_gate (
        .gie            (gie),
        .chg_hold       (chg_hold),
        .vec_sel        (vec_sel),
        .lock_app_exec  (lock_app_exec),
        .lock_boot_exec (lock_boot_exec),
        .pc_in_boot     (pc_in_boot),
        .allow          (allow)
    );

    always_comb begin
        st_d = '0;
        if (reset_evt) begin
            st_d.valid = 1'b1;
            st_d.addr  = ADDR_W'(reset_addr);
        end else if (allow && hit) begin
            st_d.valid        = 1'b1;
            st_d.addr         = ADDR_W'(irq_base) + ADDR_W'(win_idx) + ADDR_W'(1);
            st_d.ack[win_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_valid = st_q.valid;
    assign vec_addr  = st_q.addr;
    assign vec_ack   = st_q.ack;
endmodule

// File: rtl/ivg_checker.sv
module ivg_checker #(
    parameter int unsigned SRC_N  = 18,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_evt,
    input logic [SRC_N-1:0]  irq_req,
    input logic              gie,
    input logic              vec_sel,
    input logic              lock_app_exec,
    input logic              lock_boot_exec,
    input logic              pc_in_boot,
    input logic              chg_hold,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [SRC_N-1:0]  vec_ack
);
    a_r12_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_ack));

    a_r12_ack_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack != '0) |-> vec_valid);

    a_r12_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_addr == '0 && vec_ack == '0));

    a_r2_reset_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt |=> (vec_valid && vec_ack == '0));

    a_r8_gie_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_evt && !gie) |=> !vec_valid);

    a_r11_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_evt && chg_hold) |=> !vec_valid);

    a_r9_app_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_evt && vec_sel && lock_app_exec && !pc_in_boot) |=> !vec_valid);

    a_r10_boot_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_evt && !vec_sel && lock_boot_exec && pc_in_boot) |=> !vec_valid);

    a_r7_ack_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack != '0) |-> ((vec_ack & $past(irq_req)) == vec_ack));

    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack != '0) |-> (((vec_ack - 1'b1) & $past(irq_req)) == '0));
endmodule

bind irq_vector_gen ivg_checker #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reset_evt      (reset_evt),
    .irq_req        (irq_req),
    .gie            (gie),
    .vec_sel        (vec_sel),
    .lock_app_exec  (lock_app_exec),
    .lock_boot_exec (lock_boot_exec),
    .pc_in_boot     (pc_in_boot),
    .chg_hold       (chg_hold),
    .vec_valid      (vec_valid),
    .vec_addr       (vec_addr),
    .vec_ack        (vec_ack)
);

// File: tb/irq_vector_gen_tb_top.sv
module irq_vector_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reset_evt;
    logic [17:0] irq_req;
    logic        gie, boot_rst_n, vec_sel;
    logic [1:0]  boot_size;
    logic        lock_app_exec, lock_boot_exec, pc_in_boot, chg_hold;
    logic        vec_valid;
    logic [11:0] vec_addr;
    logic [17:0] vec_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    irq_vector_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .irq_req(irq_req),
        .gie(gie), .boot_rst_n(boot_rst_n), .vec_sel(vec_sel),
        .boot_size(boot_size), .lock_app_exec(lock_app_exec),
        .lock_boot_exec(lock_boot_exec), .pc_in_boot(pc_in_boot),
        .chg_hold(chg_hold), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .vec_ack(vec_ack)
    );

    function automatic logic [11:0] exp_boot(input logic [1:0] sz);
        case (sz)
            2'b00:   return 12'h800;
            2'b01:   return 12'hC00;
            2'b10:   return 12'hE00;
            default: return 12'hF00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reset_evt = 0; irq_req = '0; gie = 1; boot_rst_n = 1; vec_sel = 0;
        boot_size = 2'b01; lock_app_exec = 0; lock_boot_exec = 0;
        pc_in_boot = 0; chg_hold = 0;
    endtask

    // inputs already set after a negedge; observe one clock later, then idle
    task automatic step_out();
        @(negedge clk);
    endtask

    task automatic expect_vec(input string req, input logic [11:0] addr, input logic [17:0] ack);
        step_out();
        check(req, {31'd0, vec_valid}, 32'd1);
        check(req, {20'd0, vec_addr}, {20'd0, addr});
        check(req, {14'd0, vec_ack}, {14'd0, ack});
        idle();
    endtask

    task automatic expect_none(input string req);
        step_out();
        check(req, {31'd0, vec_valid}, 32'd0);
        check(req, {14'd0, vec_ack}, 32'd0);
        check(req, {20'd0, vec_addr}, 32'd0);
        idle();
    endtask

    task automatic t_reset_state();
        check("R1", {31'd0, vec_valid}, 32'd0);
        check("R1", {14'd0, vec_ack}, 32'd0);
        check("R1", {20'd0, vec_addr}, 32'd0);
    endtask

    task automatic t_reset_vectors();
        // R2: unprogrammed, ignores gating and requests
        reset_evt = 1; irq_req = 18'h3FFFF; gie = 0; chg_hold = 1;
        expect_vec("R2", 12'h000, '0);
        // R3/R4: programmed, each boot size
        for (int s = 0; s < 4; s++) begin
            reset_evt = 1; boot_rst_n = 0; boot_size = 2'(s);
            expect_vec("R3_R4", exp_boot(2'(s)), '0);
        end
        // R7: reset overrides pending interrupt
        reset_evt = 1; irq_req = 18'h00001;
        expect_vec("R7", 12'h000, '0);
    endtask

    task automatic t_app_table();
        for (int i = 0; i < 18; i++) begin
            irq_req = 18'(1) << i;
            expect_vec("R5", 12'(i + 1), 18'(1) << i);
        end
    endtask

    task automatic t_boot_table();
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 18; i += 17) begin
                vec_sel = 1; pc_in_boot = 1; boot_size = 2'(s);
                irq_req = 18'(1) << i;
                expect_vec("R6", exp_boot(2'(s)) + 12'(i + 1), 18'(1) << i);
            end
        end
        vec_sel = 1; boot_size = 2'b01; irq_req = 18'h00400;
        expect_vec("R6", 12'hC0B, 18'h00400);
    endtask

    task automatic t_priority();
        irq_req = 18'h3FFFF;
        expect_vec("R7", 12'h001, 18'h00001);
        irq_req = 18'h20110;
        expect_vec("R7", 12'h005, 18'h00010);
        irq_req = 18'h30000;
        expect_vec("R7", 12'h011, 18'h10000);
    endtask

    task automatic t_gie();
        gie = 0; irq_req = 18'h00022;
        expect_none("R8");
    endtask

    task automatic t_locks();
        vec_sel = 1; lock_app_exec = 1; pc_in_boot = 0; irq_req = 18'h00004;
        expect_none("R9");
        vec_sel = 1; lock_app_exec = 1; pc_in_boot = 1; irq_req = 18'h00004;
        expect_vec("R9", 12'hC03, 18'h00004);
        lock_boot_exec = 1; pc_in_boot = 1; irq_req = 18'h00008;
        expect_none("R10");
        lock_boot_exec = 1; pc_in_boot = 0; irq_req = 18'h00008;
        expect_vec("R10", 12'h004, 18'h00008);
        // app lock does not apply when table is in application space
        lock_app_exec = 1; pc_in_boot = 0; irq_req = 18'h00008;
        expect_vec("R9", 12'h004, 18'h00008);
    endtask

    task automatic t_hold();
        chg_hold = 1; irq_req = 18'h00001;
        expect_none("R11");
        irq_req = 18'h00001;
        expect_vec("R11", 12'h001, 18'h00001);
        step_out();
        check("R12", {31'd0, vec_valid}, 32'd0);
        check("R12", {20'd0, vec_addr}, 32'd0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_reset_vectors();
        t_app_table();
        t_boot_table();
        t_priority();
        t_gie();
        t_locks();
        t_hold();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule